// File: doc/BRIEF.md
# Channel Interrupt Status Register Bank

This block keeps one pending-interrupt flag for each of 64 logical channels and presents them to a host as two 32-bit status words on a simple register bus. A one-cycle pulse on a channel's event input raises that channel's flag. The flag then stays up until the host clears it. The lower word, at byte offset 0x7D0, carries channels 31 down to 0. The upper word, at 0x7D4, carries channels 63 down to 32. A single combined interrupt output is high while any flag is pending.

A control register at 0x7D8 holds one bit that picks the clear policy. With the bit at 0, reading a status word clears the flags that the read returned. With the bit at 1, reads leave the flags alone, and software clears flags by writing ones to them. In both modes a hardware event wins over any clear of the same bit in the same cycle, so no event is lost. Read data comes back one clock after the read request. An address that matches no register reads as zero and changes nothing.

Top module: `chan_irq_status_bank`

## Requirements
- R1: After reset, every flag is 0, the clear-mode bit is 0, the read data is 0 and the interrupt output is low.
- R2: An event pulse on channel c sets its flag. Channel c appears at bit c of the word at 0x7D0 for c < 32, and at bit c-32 of the word at 0x7D4 for c >= 32.
- R3: A read sampled on a clock edge returns its data on the read data port from the next cycle onward. That data is the register contents as they stood before the edge. The port holds that value until the next read.
- R4: A write to a status word clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R5: With the clear-mode bit at 0, a read of a status word clears exactly the flags that the read returned.
- R6: With the clear-mode bit at 1, a read of a status word changes no flag.
- R7: When an event and a clear (by write or by read) hit the same flag in the same cycle, the flag ends up set.
- R8: The control register at 0x7D8 stores the clear-mode bit in bit 0. Bit 0 reads back as written, and bits 31:1 read as 0.
- R9: A read of an unmapped offset returns 0. An access of any kind to an unmapped offset leaves every flag and the clear-mode bit unchanged.
- R10: The interrupt output is the OR of all 64 flags. It rises in the cycle after an event and falls in the cycle after the last pending flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| event_i | input | 64 | Per-channel event pulses, bit c = channel c |
| irq_o | output | 1 | Combined interrupt, high while any flag is pending |

## Verification
The bench builds the block with its default parameters: 64 channels in two 32-bit words based at 0x7D0, with the control word at 0x7D8. Because there are two words, a word-index error or a swapped half shows up right away. Two channels sit at the very edges of the map, channel 0 and channel 63. The address space is large enough that unmapped offsets at 0x7DC and 0x7E0 fall just past the control register, which tests the boundary of the decoder.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int BUS_W = 32;

    // Decoded access strobes for one bus cycle
    typedef struct packed {
        logic rd;
        logic wr;
        logic ctrl_hit;
        logic miss;
    } acc_t;
endpackage

// File: rtl/chan_irq_decode.sv
module chan_irq_decode #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 2,
    parameter int BASE_OFFS = 'h7D0
) (
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [NUM_WORDS-1:0]  word_hit_o,
    output chan_irq_pkg::acc_t    acc_o
);
    localparam int STRIDE    = chan_irq_pkg::BUS_W / 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_OFFS + STRIDE * NUM_WORDS);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word_dec
        localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(BASE_OFFS + STRIDE * w);
        assign word_hit_o[w] = sel_i && (addr_i == WORD_ADDR);
    end

    always_comb begin
        acc_o.rd       = sel_i && !wr_i;
        acc_o.wr       = sel_i && wr_i;
        acc_o.ctrl_hit = sel_i && (addr_i == CTRL_ADDR);
        acc_o.miss     = sel_i && !acc_o.ctrl_hit && (word_hit_o == '0);
    end
endmodule

// File: rtl/chan_irq_word.sv
module chan_irq_word #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] evt_i,
    input  logic              hit_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              cor_en_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] flags_o
);
    typedef struct packed {
        logic [WORD_W-1:0] flags;
    } word_st_t;

    word_st_t st_d, st_q;
    logic [WORD_W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (hit_i && wr_i)
            clr_mask = wdata_i;
        else if (hit_i && rd_i && cor_en_i)
            clr_mask = st_q.flags;
        st_d       = st_q;
        // Event set is applied last so it wins over a same-cycle clear
        st_d.flags = (st_q.flags & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/chan_irq_status_bank.sv
module chan_irq_status_bank #(
    parameter int NUM_CH    = 64,
    parameter int ADDR_W    = 12,
    parameter int BASE_OFFS = 'h7D0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [chan_irq_pkg::BUS_W-1:0] bus_wdata,
    output logic [chan_irq_pkg::BUS_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0]              event_i,
    output logic                           irq_o
);
    import chan_irq_pkg::*;

    localparam int WORD_W    = BUS_W;
    localparam int NUM_WORDS = (NUM_CH + WORD_W - 1) / WORD_W;
    localparam int PAD_CH    = NUM_WORDS * WORD_W;

    typedef struct packed {
        logic             mode;   // 1: write-one-to-clear only, 0: clear on read
        logic [BUS_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_WORDS-1:0] word_hit;
    acc_t                 acc;
    logic [PAD_CH-1:0]    evt_pad;
    logic [PAD_CH-1:0]    flags_pad;
    logic [NUM_CH-1:0]    flags_all;
    logic                 mode_w;

    chan_irq_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .BASE_OFFS(BASE_OFFS)
    ) dec_i (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .word_hit_o(word_hit),
        .acc_o     (acc)
    );

    assign evt_pad = PAD_CH'(event_i);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        chan_irq_word #(.WORD_W(WORD_W)) word_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_pad[w*WORD_W +: WORD_W]),
            .hit_i   (word_hit[w]),
            .rd_i    (acc.rd),
            .wr_i    (acc.wr),
            .cor_en_i(!st_q.mode),
            .wdata_i (bus_wdata),
            .flags_o (flags_pad[w*WORD_W +: WORD_W])
        );
    end

    assign flags_all = flags_pad[NUM_CH-1:0];

    always_comb begin
        st_d = st_q;
        if (acc.rd) begin
            st_d.rdata = '0;
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (word_hit[w])
                    st_d.rdata = st_d.rdata | flags_pad[w*WORD_W +: WORD_W];
            end
            if (acc.ctrl_hit)
                st_d.rdata = BUS_W'(st_q.mode);
        end
        if (acc.wr && acc.ctrl_hit)
            st_d.mode = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign mode_w    = st_q.mode;
    assign irq_o     = |flags_all;
endmodule

// File: rtl/chan_irq_checker.sv
module chan_irq_checker #(
    parameter int NUM_CH    = 64,
    parameter int ADDR_W    = 12,
    parameter int BASE_OFFS = 'h7D0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] event_i,
    input logic              irq_o,
    input logic [NUM_CH-1:0] flags,
    input logic              mode
);
    localparam int NW = (NUM_CH + 31) / 32;

    logic [NW*32-1:0] wmask_pad;
    logic [NUM_CH-1:0] wmask;
    logic              unmapped;

    always_comb begin
        wmask_pad = '0;
        unmapped  = bus_sel && (bus_addr != ADDR_W'(BASE_OFFS + 4 * NW));
        for (int w = 0; w < NW; w++) begin
            if (bus_addr == ADDR_W'(BASE_OFFS + 4 * w)) begin
                wmask_pad[w*32 +: 32] = bus_wdata;
                unmapped = 1'b0;
            end
        end
    end
    assign wmask = wmask_pad[NUM_CH-1:0];

    a_r2_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> ((flags & $past(event_i)) == $past(event_i)));

    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && event_i == '0) |=> ((flags & $past(wmask)) == '0));

    a_r6_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && mode) |=> ((flags & $past(flags)) == $past(flags)));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (unmapped && !bus_wr) |=> (bus_rdata == '0));

    a_r9_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |=> (((flags & $past(flags)) == $past(flags)) && $stable(mode)));

    a_r10_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> irq_o);
endmodule

bind chan_irq_status_bank chan_irq_checker #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .BASE_OFFS(BASE_OFFS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .event_i  (event_i),
    .irq_o    (irq_o),
    .flags    (flags_all),
    .mode     (mode_w)
);

// File: tb/chan_irq_status_bank_tb.sv
`timescale 1ns/1ps
module chan_irq_status_bank_tb_top;
    localparam logic [11:0] A_LO = 12'h7D0;
    localparam logic [11:0] A_HI = 12'h7D4;
    localparam logic [11:0] A_CT = 12'h7D8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] ev = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [63:0] m_flags;
    logic        m_mode;
    logic [31:0] m_rd;

    always #2.5 clk = ~clk;

    chan_irq_status_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .event_i(ev), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = '0; m_mode = 1'b0; m_rd = '0;
        end else begin
            logic [63:0] clr;
            int widx;
            clr  = '0;
            widx = -1;
            if (bus_addr == A_LO) widx = 0;
            if (bus_addr == A_HI) widx = 1;
            if (bus_sel && !bus_wr) begin
                if (widx >= 0) begin
                    m_rd = m_flags[widx*32 +: 32];
                    if (!m_mode) clr[widx*32 +: 32] = m_flags[widx*32 +: 32];
                end else if (bus_addr == A_CT) m_rd = {31'b0, m_mode};
                else m_rd = '0;
            end
            if (bus_sel && bus_wr) begin
                if (widx >= 0) clr[widx*32 +: 32] = bus_wdata;
                else if (bus_addr == A_CT) m_mode = bus_wdata[0];
            end
            m_flags = (m_flags & ~clr) | ev;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (bus_rdata !== m_rd) begin
                fails++;
                $display("FAIL R3 model rdata actual=%h expected=%h", bus_rdata, m_rd);
            end
            checks++;
            if (irq_o !== (m_flags != '0)) begin
                fails++;
                $display("FAIL R10 model irq actual=%b expected=%b", irq_o, (m_flags != '0));
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic do_read(logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0; ev = '0;
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev = '0;
    endtask

    task automatic pulse(logic [63:0] m);
        ev = m;
        @(negedge clk);
        ev = '0;
    endtask

    initial begin
        #(5ns * 20000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        check("R1 irq after reset", 32'(irq_o), 32'h0);
        do_read(A_LO, d); check("R1 low word", d, 32'h0);
        do_read(A_HI, d); check("R1 high word", d, 32'h0);
        do_read(A_CT, d); check("R1 R8 mode reset", d, 32'h0);

        // Clear-on-read mode
        pulse(64'h0000_0100_0000_0020);   // channels 5 and 40
        check("R10 irq after event", 32'(irq_o), 32'h1);
        do_read(A_HI, d); check("R2 channel 40 in high word", d, 32'h0000_0100);
        do_read(A_HI, d); check("R5 high cleared by read", d, 32'h0);
        check("R10 irq still up", 32'(irq_o), 32'h1);
        do_read(A_LO, d); check("R2 channel 5 in low word", d, 32'h0000_0020);
        check("R10 irq falls after last clear", 32'(irq_o), 32'h0);

        // Read with a same-cycle event on the returned bit
        pulse(64'h8);
        ev = 64'h8;
        do_read(A_LO, d); check("R5 returned data", d, 32'h8);
        do_read(A_LO, d); check("R7 event beats read clear", d, 32'h8);
        do_read(A_LO, d); check("R5 cleared after read", d, 32'h0);

        // Write-one-to-clear mode
        do_write(A_CT, 32'hFFFF_FFFF);
        do_read(A_CT, d); check("R8 mode reads back, upper zero", d, 32'h1);
        pulse(64'h8000_0000_0000_0001);   // channels 0 and 63
        do_read(A_LO, d); check("R2 channel 0", d, 32'h1);
        do_read(A_LO, d); check("R6 read does not clear", d, 32'h1);
        do_read(A_HI, d); check("R2 channel 63", d, 32'h8000_0000);
        do_write(A_LO, 32'h0);
        do_read(A_LO, d); check("R4 zero write keeps", d, 32'h1);
        do_write(A_HI, 32'h8000_0000);
        do_read(A_HI, d); check("R4 one write clears", d, 32'h0);
        ev = 64'h1;
        do_write(A_LO, 32'h1);
        do_read(A_LO, d); check("R7 event beats write clear", d, 32'h1);
        do_write(A_LO, 32'h1);
        check("R10 irq falls after write clear", 32'(irq_o), 32'h0);

        // Unmapped offsets
        pulse(64'h0000_0004_0000_0000);
        do_read(12'h7DC, d); check("R9 unmapped reads zero", d, 32'h0);
        do_write(12'h7E0, 32'hFFFF_FFFF);
        do_write(12'h7D2, 32'hFFFF_FFFF);
        do_read(A_HI, d); check("R9 flags untouched", d, 32'h4);
        do_read(A_CT, d); check("R9 mode untouched", d, 32'h1);
        do_write(A_CT, 32'h0);
        do_read(A_CT, d); check("R8 mode written to zero", d, 32'h0);

        // Pseudo-random traffic, checked cycle by cycle against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ev = (lfsr[2:0] == 3'd0) ? (64'h1 << lfsr[8:3]) |
                                      (64'h1 << lfsr[14:9]) : 64'h0;
            bus_sel   = lfsr[4] | lfsr[11];
            bus_wr    = lfsr[7] & lfsr[1];
            bus_addr  = 12'h7D0 + 12'(lfsr[6:5]) * 12'd4 + ((lfsr[15:12] == 4'hF) ? 12'h10 : 12'h0);
            bus_wdata = {lfsr, lfsr[0], lfsr[15:1]} & {32{lfsr[3]}} | {31'b0, lfsr[9]};
            @(negedge clk);
        end
        bus_sel = 1'b0; ev = '0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule